// File: doc/BRIEF.md
# Three-product split multiplier

This block multiplies two unsigned operands of `W` bits (8 by default) and returns their full `2W`-bit product. It has no clock or state: the product settles from the inputs through combinational logic. It is meant as a drop-in arithmetic leaf where the critical path of a plain array multiplier is too long.

Each operand is cut into a low half and a high half of `W/2` bits. Only three half-size multiplications are formed:

- the product of the two low halves;
- the product of the two high halves;
- the product of the two half sums, where each half sum is `W/2+1` bits so the carry is kept.

The middle term is the cross product minus the other two. The three terms are then placed at bit offsets 0, `W/2` and `W` and added. `W` must be even.

Top module: `kara_mul`

## Requirements
- R1: For every pair of unsigned `W`-bit inputs `a`, `b`, the output `d` equals `a*b` as a `2W`-bit unsigned value. With the default `W=8`, this holds for all 65536 pairs.
- R2: The low half of an operand is its bits `[W/2-1:0]` and the high half is bits `[W-1:W/2]`. Their sum is `W/2+1` bits wide, so a carry out of the half sum still reaches the product (for example `a=255`, `b=15` gives 3825).
- R3: The middle term, cross product minus both half products, is never negative. It enters the result at bit offset `W/2` (for example `a=15`, `b=240` gives 3600).
- R4: The block is purely combinational. When the inputs change, `d` reflects the new pair within the same clock period, with no latency and no memory of earlier inputs.
- R5: Inputs 8 and 10 give 80.
- R6: The largest inputs (255 by 255 at `W=8`) give 65025, with no truncation.
- R7: If either input is zero, `d` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| d | output | 2W | Full unsigned product |

## Verification
A fault in one of the three half products, or a lost carry in a half sum, shows on `d` in the same cycle, but only for the operand pairs that use that path. A dropped carry, for instance, appears only when both halves of an operand sum past `2^(W/2)-1`. For this reason every pair at `W=8` is compared against a reference product. Directed pairs are also applied to target carries, a middle term placed at offset `W/2`, zero operands and the all-ones corner.

// File: rtl/kara_pkg.sv
`timescale 1ns/1ps
package kara_pkg;
  // half width for an even operand width
  function automatic int half_w(input int w);
    return w / 2;
  endfunction

  // width of a half sum, one carry bit above a half
  function automatic int hsum_w(input int w);
    return w / 2 + 1;
  endfunction
endpackage

// File: rtl/kara_split.sv
`timescale 1ns/1ps
module kara_split #(
  parameter int W = 8
) (
  input  logic [W-1:0]              op,
  output logic [kara_pkg::half_w(W)-1:0] lo,
  output logic [kara_pkg::half_w(W)-1:0] hi,
  output logic [kara_pkg::half_w(W):0]   hsum
);
  localparam int H = kara_pkg::half_w(W);

  assign lo   = op[H-1:0];
  assign hi   = op[W-1:H];
  assign hsum = {1'b0, lo} + {1'b0, hi};

  // R2: the carry of a half sum can only come from two nonzero halves
  always_comb begin
    if (hsum[H]) begin
      a_r2_carry_needs_both: assert (lo != '0 && hi != '0)
        else $error("R2 half-sum carry with a zero half");
    end
  end
endmodule

// File: rtl/kara_halfmul.sv
`timescale 1ns/1ps
module kara_halfmul #(
  parameter int N = 4
) (
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   y,
  output logic [2*N-1:0] p
);
  function automatic logic [2*N-1:0] shift_add(input logic [N-1:0] m,
                                               input logic [N-1:0] q);
    logic [2*N-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (q[i]) acc = acc + ({{N{1'b0}}, m} << i);
    end
    return acc;
  endfunction

  assign p = shift_add(x, y);

  // R7: a zero factor gives a zero partial product
  always_comb begin
    if (x == '0 || y == '0) begin
      a_r7_part_zero: assert (p == '0)
        else $error("R7 partial product nonzero for zero factor");
    end
  end
endmodule

// File: rtl/kara_combine.sv
`timescale 1ns/1ps
module kara_combine #(
  parameter int W = 8
) (
  input  logic [W-1:0]   z_lo,
  input  logic [W-1:0]   z_hi,
  input  logic [W+1:0]   z_x,
  output logic [2*W-1:0] d
);
  localparam int H = kara_pkg::half_w(W);

  logic [W+1:0]   mid;
  logic [W+1:0]   outer_sum;
  logic [2*W-1:0] mid_ext;

  assign outer_sum = {2'b00, z_lo} + {2'b00, z_hi};
  assign mid       = z_x - outer_sum;
  assign mid_ext   = {{(W-2){1'b0}}, mid};
  // z_lo < 2^W, so concatenation equals z_hi*2^W + z_lo
  assign d         = {z_hi, z_lo} + (mid_ext << H);

  // R3: middle term never negative, and fits below bit W+1
  always_comb begin
    a_r3_mid_nonneg: assert (z_x >= outer_sum)
      else $error("R3 cross product below outer sum");
    a_r3_mid_bound: assert (mid[W+1] == 1'b0)
      else $error("R3 middle term out of range");
  end
endmodule

// File: rtl/kara_mul.sv
`timescale 1ns/1ps
module kara_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] d
);
  localparam int H = kara_pkg::half_w(W);

  logic [1:0][W-1:0] ops;
  logic [1:0][H-1:0] lo_q;
  logic [1:0][H-1:0] hi_q;
  logic [1:0][H:0]   hs_q;
  logic [W-1:0]      z_lo;
  logic [W-1:0]      z_hi;
  logic [W+1:0]      z_x;

  assign ops[0] = a;
  assign ops[1] = b;

  for (genvar g = 0; g < 2; g++) begin : g_split
    kara_split #(.W(W)) split_i (
      .op  (ops[g]),
      .lo  (lo_q[g]),
      .hi  (hi_q[g]),
      .hsum(hs_q[g])
    );
  end

  kara_halfmul #(.N(H)) mul_lo_i (.x(lo_q[0]), .y(lo_q[1]), .p(z_lo));
  kara_halfmul #(.N(H)) mul_hi_i (.x(hi_q[0]), .y(hi_q[1]), .p(z_hi));
  kara_halfmul #(.N(H+1)) mul_x_i (.x(hs_q[0]), .y(hs_q[1]), .p(z_x));

  kara_combine #(.W(W)) comb_i (
    .z_lo(z_lo),
    .z_hi(z_hi),
    .z_x (z_x),
    .d   (d)
  );

  // R1, R6, R7 at the ports
  always_comb begin
    a_r1_exact: assert (d == ({{W{1'b0}}, a} * {{W{1'b0}}, b}))
      else $error("R1 product mismatch");
    if (a == '0 || b == '0) begin
      a_r7_zero_in: assert (d == '0)
        else $error("R7 zero operand gave nonzero product");
    end
    if (a == '1 && b == '1) begin
      a_r6_no_overflow: assert (d[2*W-1] == 1'b1 && d[0] == 1'b1)
        else $error("R6 top corner product truncated");
    end
  end
endmodule

// File: tb/kara_mul_tb_top.sv
`timescale 1ns/1ps
module kara_mul_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]   a = '0;
  logic [W-1:0]   b = '0;
  logic [2*W-1:0] d;

  kara_mul #(.W(W)) dut_i (.a(a), .b(b), .d(d));

  typedef struct {
    logic [W-1:0]   xa;
    logic [W-1:0]   xb;
    logic [2*W-1:0] exp;
    string          tag;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad   = 0;

  task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input string tag);
    item_t it;
    @(posedge clk);
    #1;
    a = xa;
    b = xb;
    it.xa  = xa;
    it.xb  = xb;
    it.exp = {{W{1'b0}}, xa} * {{W{1'b0}}, xb};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: sample mid-period, compare against queued expectation
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (d !== it.exp) begin
        bad++;
        $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d",
                 it.tag, it.xa, it.xb, d, it.exp);
      end
    end
  end

  initial begin
    // idle state with zero inputs
    #2;
    total++;
    if (d !== '0) begin
      bad++;
      $display("FAIL R7 idle actual=%0d expected=0", d);
    end
    drive(8'd8,   8'd10,  "R5 example");
    drive(8'd255, 8'd255, "R6 top corner");
    drive(8'd0,   8'd200, "R7 zero a");
    drive(8'd173, 8'd0,   "R7 zero b");
    drive(8'hFF,  8'h0F,  "R2 half-sum carry");
    drive(8'h88,  8'h88,  "R2 both carries");
    drive(8'h0F,  8'hF0,  "R3 middle only");
    drive(8'hF0,  8'h0F,  "R3 middle swapped");
    drive(8'd1,   8'd255, "R4 step one");
    drive(8'd254, 8'd2,   "R4 step two");
    drive(8'd3,   8'd3,   "R4 step three");
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        drive(W'(ia), W'(ib), "R1 sweep");
      end
    end
    while (sb_q.size() > 0) @(negedge clk);
    @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule